// File: doc/BRIEF.md
# Prescaled PWM Channel with End-of-Period Update

This block drives one pulse-width-modulated output. The input clock is first divided by a power of two chosen by a 4-bit prescaler field. The divided ticks advance a period counter. Every period opens at the inactive level. The output turns active once the counter reaches the programmed duty count. The active part of a period is therefore the period count minus the duty count.

While the channel is stopped, the period and duty registers are written directly. While it runs, software changes one of them through a single update register. A mode bit chooses whether that update goes to the duty value or to the period value. The update is held until the current period ends, so the waveform never shows a partial period. A one-cycle period-start pulse tells the surrounding logic when a new period has begun, and so when a held update has been applied. A channel enable from the global controller starts the channel at once. When the enable is removed, the channel still finishes the period in progress before it stops.

Top module: `pwm_chan`

## Requirements
- R1: After reset the channel is stopped: `running_o`=0, `period_start_o`=0, and `pwm_o`=0 (the polarity bit resets to 0).
- R2: The counter advances once every 2^p input clocks. p is the `cfg_psc` value held in the mode register. Any field value above 10 acts as 10.
- R3: A period of value P lasts max(P,1)·2^p clocks. With duty value D, the output is inactive while the counter is below D and active from D on, which gives (P−D)·2^p active clocks.
- R4: With polarity bit 1 the active level is 0 and the inactive level is 1, both while running and while stopped. With polarity bit 0 the active level is 1.
- R5: A `wr_update` write made while running changes nothing until the next period start. At that start the held value takes effect. A later write made before that start replaces the held one.
- R6: The update target is the mode-register bit in force at the time of the write: 0 selects duty and 1 selects period.
- R7: `period_start_o` is high for exactly the first clock of every period, including the first period after enable. It is high only while running.
- R8: While stopped, `wr_duty`, `wr_period` and `wr_update` load the live registers at once. `wr_mode` loads all three mode fields. `pwm_o` stays at the inactive level.
- R9: When `chan_en` is low at the end of a period, the channel stops there. `running_o` falls one clock after the last clock of that period, and `pwm_o` returns to the inactive level.
- R10: A duty value of 0 gives an output that is active for the whole period. A duty value of at least the period value gives an output that is never active.
- R11: While running, `wr_duty` and `wr_period` are ignored, and `wr_mode` changes only the update-target bit. Prescaler and polarity keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chan_en | input | 1 | Channel enable from the global controller (level) |
| cfg_psc | input | 4 | Prescaler exponent, stored on `wr_mode` |
| cfg_inv | input | 1 | Polarity bit, stored on `wr_mode` |
| cfg_sel | input | 1 | Update target (0 duty, 1 period), stored on `wr_mode` |
| wr_mode | input | 1 | Mode-register write strobe |
| wr_duty | input | 1 | Direct duty write strobe |
| wr_period | input | 1 | Direct period write strobe |
| wr_update | input | 1 | Update-register write strobe |
| wr_data | input | PERIOD_W | Data for duty, period and update writes |
| pwm_o | output | 1 | PWM waveform |
| period_start_o | output | 1 | One-clock pulse at each period start |
| running_o | output | 1 | Channel running status |

## Verification
A corrupt prescaler or period counter shifts the next output edge, and the next period-start pulse lands on the wrong clock. A lost or early held update changes the active length of the following period. A wrong run state shows on `running_o` and on the idle output level in the very clock that follows. The bench runs a behavioural model next to the design and compares all three outputs on every clock. It also measures whole periods against lengths computed from the requirements, so any of these faults shows up within one period of its cause.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;
   localparam int PSC_W   = 4;
   localparam int MAX_PSC = 10;

   typedef enum logic {
      TGT_DUTY   = 1'b0,
      TGT_PERIOD = 1'b1
   } upd_tgt_e;
endpackage

// File: rtl/pwm_chan_prescaler.sv
module pwm_chan_prescaler
   import pwm_chan_pkg::*;
#(
   parameter int P_W  = PSC_W,
   parameter int P_MAX = MAX_PSC
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           run,
   input  logic [P_W-1:0] psc,
   output logic           tick
);
   localparam int DIV_W = P_MAX;

   logic [P_W-1:0]   psc_eff;
   logic [DIV_W-1:0] term;
   logic [DIV_W-1:0] div_q;

   always_comb psc_eff = (int'(psc) > P_MAX) ? P_W'(P_MAX) : psc;

   // terminal count is 2^p - 1: the low p bits set
   always_comb begin
      for (int i = 0; i < DIV_W; i++) term[i] = (i < int'(psc_eff));
   end

   assign tick = run && (div_q == term);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              div_q <= '0;
      else if (!run || tick)   div_q <= '0;
      else                     div_q <= div_q + 1'b1;
   end
endmodule

// File: rtl/pwm_chan_counter.sv
module pwm_chan_counter #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic         tick,
   input  logic [W-1:0] period,
   output logic [W-1:0] cnt,
   output logic         wrap
);
   logic [W-1:0] last_val;

   always_comb last_val = (period == '0) ? '0 : period - W'(1);

   assign wrap = tick && (cnt >= last_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt <= '0;
      else if (!run)     cnt <= '0;
      else if (tick) begin
         if (wrap)       cnt <= '0;
         else            cnt <= cnt + W'(1);
      end
   end
endmodule

// File: rtl/pwm_chan_regs.sv
module pwm_chan_regs
   import pwm_chan_pkg::*;
#(
   parameter int W   = 16,
   parameter int P_W = PSC_W
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           running,
   input  logic           boundary,
   input  logic           wr_mode,
   input  logic [P_W-1:0] cfg_psc,
   input  logic           cfg_inv,
   input  logic           cfg_sel,
   input  logic           wr_duty,
   input  logic           wr_period,
   input  logic           wr_update,
   input  logic [W-1:0]   wr_data,
   output logic [W-1:0]   duty_q,
   output logic [W-1:0]   per_q,
   output logic [P_W-1:0] psc_q,
   output logic           inv_q
);
   upd_tgt_e     sel_q;
   upd_tgt_e     tgt_q;
   logic         pend_q;
   logic [W-1:0] buf_q;

   // mode register: target bit always writable, the rest only while stopped
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= TGT_DUTY;
         psc_q <= '0;
         inv_q <= 1'b0;
      end else if (wr_mode) begin
         sel_q <= upd_tgt_e'(cfg_sel);
         if (!running) begin
            psc_q <= cfg_psc;
            inv_q <= cfg_inv;
         end
      end
   end

   // live duty/period and the held update
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         duty_q <= '0;
         per_q  <= '0;
         pend_q <= 1'b0;
         buf_q  <= '0;
         tgt_q  <= TGT_DUTY;
      end else if (!running) begin
         pend_q <= 1'b0;
         if (wr_duty)   duty_q <= wr_data;
         if (wr_period) per_q  <= wr_data;
         if (wr_update) begin
            if (sel_q == TGT_PERIOD) per_q  <= wr_data;
            else                     duty_q <= wr_data;
         end
      end else begin
         if (boundary && pend_q) begin
            if (tgt_q == TGT_PERIOD) per_q  <= buf_q;
            else                     duty_q <= buf_q;
         end
         if (wr_update) begin
            pend_q <= 1'b1;
            buf_q  <= wr_data;
            tgt_q  <= sel_q;
         end else if (boundary) begin
            pend_q <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
   import pwm_chan_pkg::*;
#(
   parameter int PERIOD_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                chan_en,
   input  logic [PSC_W-1:0]    cfg_psc,
   input  logic                cfg_inv,
   input  logic                cfg_sel,
   input  logic                wr_mode,
   input  logic                wr_duty,
   input  logic                wr_period,
   input  logic                wr_update,
   input  logic [PERIOD_W-1:0] wr_data,
   output logic                pwm_o,
   output logic                period_start_o,
   output logic                running_o
);
   generate
      if (!(PERIOD_W == 16 || PERIOD_W == 32)) begin : g_bad_width
         $error("pwm_chan: PERIOD_W must be 16 or 32");
      end
      if (MAX_PSC < 1 || (1 << PSC_W) <= MAX_PSC) begin : g_bad_psc
         $error("pwm_chan: prescaler field cannot hold its limit");
      end
   endgenerate

   logic                run_q;
   logic                start_q;
   logic                tick;
   logic                wrap;
   logic [PERIOD_W-1:0] cnt;
   logic [PERIOD_W-1:0] duty_q;
   logic [PERIOD_W-1:0] per_q;
   logic [PSC_W-1:0]    psc_q;
   logic                inv_q;

   pwm_chan_regs #(.W(PERIOD_W), .P_W(PSC_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .running   (run_q),
      .boundary  (wrap),
      .wr_mode   (wr_mode),
      .cfg_psc   (cfg_psc),
      .cfg_inv   (cfg_inv),
      .cfg_sel   (cfg_sel),
      .wr_duty   (wr_duty),
      .wr_period (wr_period),
      .wr_update (wr_update),
      .wr_data   (wr_data),
      .duty_q    (duty_q),
      .per_q     (per_q),
      .psc_q     (psc_q),
      .inv_q     (inv_q)
   );

   pwm_chan_prescaler #(.P_W(PSC_W), .P_MAX(MAX_PSC)) u_psc (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run_q),
      .psc   (psc_q),
      .tick  (tick)
   );

   pwm_chan_counter #(.W(PERIOD_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run_q),
      .tick   (tick),
      .period (per_q),
      .cnt    (cnt),
      .wrap   (wrap)
   );

   // run control: start at once, stop only at a period end
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q   <= 1'b0;
         start_q <= 1'b0;
      end else begin
         start_q <= 1'b0;
         if (!run_q) begin
            if (chan_en) begin
               run_q   <= 1'b1;
               start_q <= 1'b1;
            end
         end else if (wrap) begin
            if (chan_en) start_q <= 1'b1;
            else         run_q   <= 1'b0;
         end
      end
   end

   assign pwm_o          = (run_q && (cnt >= duty_q)) ^ inv_q;
   assign period_start_o = start_q;
   assign running_o      = run_q;
endmodule

// File: rtl/pwm_chan_checker.sv
module pwm_chan_checker
   import pwm_chan_pkg::*;
#(
   parameter int PERIOD_W = 16
) (
   input logic                clk,
   input logic                rst_n,
   input logic                chan_en,
   input logic                pwm_o,
   input logic                period_start_o,
   input logic                running_o,
   input logic                inv_q,
   input logic [PSC_W-1:0]    psc_q,
   input logic [PERIOD_W-1:0] duty_q
);
   assert_start_running_R7: assert property (@(posedge clk) disable iff (!rst_n)
      period_start_o |-> running_o);

   assert_first_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(running_o) |-> period_start_o);

   assert_idle_inactive_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !running_o |-> (pwm_o == inv_q));

   assert_stop_needs_low_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(running_o) |-> !$past(chan_en));

   assert_mode_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (running_o && $past(running_o)) |-> ($stable(inv_q) && $stable(psc_q)));

   assert_duty_at_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (running_o && $past(running_o) && !period_start_o) |-> $stable(duty_q));
endmodule

bind pwm_chan pwm_chan_checker #(.PERIOD_W(PERIOD_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .chan_en        (chan_en),
   .pwm_o          (pwm_o),
   .period_start_o (period_start_o),
   .running_o      (running_o),
   .inv_q          (inv_q),
   .psc_q          (psc_q),
   .duty_q         (duty_q)
);

// File: tb/pwm_chan_bench.sv
module pwm_chan_bench;
   localparam int CLK_PERIOD = 10;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         chan_en = 1'b0;
   logic [3:0]   cfg_psc = '0;
   logic         cfg_inv = 1'b0;
   logic         cfg_sel = 1'b0;
   logic         wr_mode = 1'b0, wr_duty = 1'b0, wr_period = 1'b0, wr_update = 1'b0;
   logic [W-1:0] wr_data = '0;
   logic         pwm_o, period_start_o, running_o;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pwm_chan #(.PERIOD_W(W)) u_pwm_chan (
      .clk(clk), .rst_n(rst_n), .chan_en(chan_en),
      .cfg_psc(cfg_psc), .cfg_inv(cfg_inv), .cfg_sel(cfg_sel),
      .wr_mode(wr_mode), .wr_duty(wr_duty), .wr_period(wr_period),
      .wr_update(wr_update), .wr_data(wr_data),
      .pwm_o(pwm_o), .period_start_o(period_start_o), .running_o(running_o)
   );

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   bit     m_run, m_start, m_inv, m_sel, m_pend, m_tgt, m_tick, m_wrap, m_was_run, m_old_sel;
   int     m_psc, m_steps;
   longint m_div, m_pos, m_duty, m_per, m_buf, m_len;
   bit     model_on = 1'b0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_run = 0; m_start = 0; m_inv = 0; m_sel = 0; m_pend = 0; m_tgt = 0;
         m_psc = 0; m_div = 0; m_pos = 0; m_duty = 0; m_per = 0; m_buf = 0;
      end else begin
         m_steps   = 1 << ((m_psc > 10) ? 10 : m_psc);
         m_len     = (m_per == 0) ? 1 : m_per;
         m_tick    = m_run && (m_div == m_steps - 1);
         m_wrap    = m_tick && (m_pos + 1 >= m_len);
         m_was_run = m_run;
         m_old_sel = m_sel;
         m_start   = 0;
         if (!m_was_run) begin
            m_pend = 0;
            if (wr_duty)   m_duty = wr_data;
            if (wr_period) m_per  = wr_data;
            if (wr_update) begin
               if (m_old_sel) m_per = wr_data; else m_duty = wr_data;
            end
            if (chan_en) begin
               m_run = 1; m_start = 1; m_div = 0; m_pos = 0;
            end
         end else begin
            if (m_tick) begin
               m_div = 0;
               if (m_wrap) begin
                  m_pos = 0;
                  if (m_pend) begin
                     if (m_tgt) m_per = m_buf; else m_duty = m_buf;
                  end
                  if (chan_en) m_start = 1; else m_run = 0;
               end else m_pos = m_pos + 1;
            end else m_div = m_div + 1;
            if (wr_update) begin
               m_pend = 1; m_buf = wr_data; m_tgt = m_old_sel;
            end else if (m_wrap) m_pend = 0;
         end
         if (wr_mode) begin
            m_sel = cfg_sel;
            if (!m_was_run) begin m_psc = int'(cfg_psc); m_inv = cfg_inv; end
         end
      end
   end

   // compare every clock, away from the active edge
   always @(negedge clk) begin
      if (model_on) begin
         check(pwm_o == ((m_run && (m_pos >= m_duty)) ^ m_inv), "R3/R4 pwm_o vs model",
               longint'(pwm_o), longint'((m_run && (m_pos >= m_duty)) ^ m_inv));
         check(period_start_o == m_start, "R7 period_start_o vs model",
               longint'(period_start_o), longint'(m_start));
         check(running_o == m_run, "R9 running_o vs model",
               longint'(running_o), longint'(m_run));
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic step();
      @(posedge clk); #2;
   endtask

   task automatic set_mode(input int psc, input bit inv, input bit sel);
      cfg_psc = 4'(psc); cfg_inv = inv; cfg_sel = sel; wr_mode = 1; step(); wr_mode = 0;
   endtask

   task automatic write_duty(input int v);
      wr_data = W'(v); wr_duty = 1; step(); wr_duty = 0;
   endtask

   task automatic write_period(input int v);
      wr_data = W'(v); wr_period = 1; step(); wr_period = 0;
   endtask

   task automatic write_update(input int v);
      wr_data = W'(v); wr_update = 1; step(); wr_update = 0;
   endtask

   // measure one whole period: length and active clocks
   task automatic measure(input bit inv, output int len, output int act);
      do @(negedge clk); while (!period_start_o);
      len = 0; act = 0;
      do begin
         if (pwm_o != inv) act++;
         len++;
         @(negedge clk);
      end while (!period_start_o);
   endtask

   task automatic wait_start();
      do @(negedge clk); while (!period_start_o);
      @(posedge clk); #2;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual 1 expected 0 (run did not end)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int len, act;
      repeat (3) @(posedge clk);
      #2;
      check(pwm_o == 0, "R1 reset pwm_o", longint'(pwm_o), 0);
      check(running_o == 0, "R1 reset running_o", longint'(running_o), 0);
      check(period_start_o == 0, "R1 reset period_start_o", longint'(period_start_o), 0);
      rst_n = 1;
      model_on = 1;
      step();

      // R8: direct loads while stopped, output inactive
      set_mode(1, 0, 0);
      write_period(10);
      write_duty(3);
      @(negedge clk);
      check(pwm_o == 0, "R8 idle output inactive", longint'(pwm_o), 0);
      step();
      chan_en = 1;
      measure(0, len, act);
      check(len == 20, "R2 R3 period length psc=1 P=10", len, 20);
      check(act == 14, "R3 active clocks D=3", act, 14);

      // R5: held update applied at next period start
      wait_start();
      write_update(6);
      measure(0, len, act);
      check(act == 8, "R5 held duty update applied", act, 8);

      // R6 + R11: target bit changes while running, period update
      set_mode(1, 0, 1);
      write_update(5);
      measure(0, len, act);
      check(len == 10, "R6 update routed to period", len, 10);
      check(act == 0, "R10 duty at least period never active", act, 0);

      // R11: direct writes and prescale/polarity ignored while running
      write_duty(0);
      set_mode(0, 1, 1);
      measure(0, len, act);
      check(len == 10 && act == 0, "R11 running writes ignored", len * 100 + act, 1000);

      // R10: duty 0 always active; R5 later write replaces held one
      set_mode(0, 0, 0);
      write_update(2);
      write_update(0);
      measure(0, len, act);
      check(act == 10, "R10 duty zero always active", act, 10);
      check(act != 6, "R5 second write replaced first", act, 10);

      // R9: disable finishes the period
      wait_start();
      chan_en = 0;
      @(negedge clk);
      check(running_o == 1, "R9 still running after disable", longint'(running_o), 1);
      do @(negedge clk); while (running_o);
      check(pwm_o == 0, "R9 inactive after stop", longint'(pwm_o), 0);
      step();

      // R4 polarity + R2 prescaler clamp
      set_mode(13, 1, 0);
      write_period(2);
      write_duty(1);
      @(negedge clk);
      check(pwm_o == 1, "R4 inverted idle level", longint'(pwm_o), 1);
      step();
      chan_en = 1;
      measure(1, len, act);
      check(len == 2048, "R2 prescaler clamps to 10", len, 2048);
      check(act == 1024, "R4 inverted active clocks", act, 1024);
      chan_en = 0;
      do @(negedge clk); while (running_o);
      step();

      // R8: idle update register writes go straight to the live value
      set_mode(0, 0, 1);
      write_update(4);
      set_mode(0, 0, 0);
      write_update(1);
      chan_en = 1;
      measure(0, len, act);
      check(len == 4 && act == 3, "R8 idle update writes direct", len * 100 + act, 403);
      chan_en = 0;
      do @(negedge clk); while (running_o);
      repeat (3) @(negedge clk);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule